// File: doc/BRIEF.md
# Programmable Word Delay Line

This block delays a stream of 16-bit words by a programmable number of clock cycles. On every rising clock edge it takes one word from its data input. The same word reappears on its registered data output a fixed number of edges later. The number of edges is chosen by an 11-bit delay code. The delay in clocks is twice the code plus two, so the shortest delay is 2 clocks and the longest is 4096 clocks.

The delay code is loaded over a small side channel that is separate from the data path. Software or control logic places the code on the code bus, pulls the select line low and pulls the strobe line low. The block sees the strobe's falling edge after it has passed through a two-stage synchronizer and then takes the code. Internally the words sit in a 4096-entry circular store. The store is written at every edge. The read index trails the write index by the current delay, modulo the store size.

Top module: `prog_delay_line`

## Requirements
- R1: A word sampled on `din` at rising edge k appears on `dout` right after rising edge k+D, where D = 2*code+2 for the code in force during the whole interval.
- R2: A code of 2 gives a delay of exactly 6 clocks.
- R3: While `rst` is high at a rising edge, `dout` reads 0 after that edge. After reset the code is 0, so the delay is 2 clocks with no programming.
- R4: A falling `ds_n` while `cs_n` is high leaves the delay unchanged.
- R5: A code of 2047 gives the maximum delay of 4096 clocks.
- R6: The code on `code` is taken at the third rising edge after `ds_n` falls with `cs_n` low. The caller holds `code` and `cs_n` steady until that edge, and `ds_n` low for at least two edges. A change of `code` after that edge does not alter the delay.
- R7: After a new code is loaded, and once the new delay has passed, every word written after the change comes out with the new delay, without any reset.
- R8: Keeping `ds_n` low makes only one capture. A change of `code` while `ds_n` stays low does not alter the delay.
- R9: A code of 0 gives the minimum delay of 2 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; data moves on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 16 | Word entering the delay line |
| code | input | 11 | Delay code; delay = 2*code+2 clocks |
| cs_n | input | 1 | Active-low select for loading the code |
| ds_n | input | 1 | Active-low strobe; its falling edge loads the code |
| dout | output | 16 | Registered delayed word |

## Verification
The result of a word sampled at edge k is due just after edge k+D. The bench numbers the edges, keeps a history of the sampled words, and compares `dout` at the falling edge that follows each edge with the word from D edges earlier. A new code takes effect at the third edge after the strobe falls. The bench waits past that edge and then compares only words written after the change, so stale words in the store are never judged. The reset value is read at the falling edge after an edge with reset high.

// File: rtl/pdl_pkg.sv
package pdl_pkg;
  localparam int DATA_W  = 16;
  localparam int CODE_W  = 11;
  localparam int SYNC_N  = 2;

  typedef struct packed {
    logic cs_n;
    logic ds_n;
  } ctl_pins_t;
endpackage

// File: rtl/pdl_code_latch.sv
module pdl_code_latch #(
  parameter int CODE_W = pdl_pkg::CODE_W,
  parameter int SYNC_N = pdl_pkg::SYNC_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              ds_n,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] code_q
);
  logic [SYNC_N-1:0] ds_pipe;
  logic [SYNC_N-1:0] cs_pipe;
  logic              ds_last;
  logic              ds_s;
  logic              cs_s;
  logic              take;

  assign ds_s = ds_pipe[SYNC_N-1];
  assign cs_s = cs_pipe[SYNC_N-1];
  assign take = ds_last & ~ds_s & ~cs_s;

  generate
    if (SYNC_N == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          ds_pipe <= '1;
          cs_pipe <= '1;
        end else begin
          ds_pipe <= ds_n;
          cs_pipe <= cs_n;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          ds_pipe <= '1;
          cs_pipe <= '1;
        end else begin
          ds_pipe <= {ds_pipe[SYNC_N-2:0], ds_n};
          cs_pipe <= {cs_pipe[SYNC_N-2:0], cs_n};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ds_last <= 1'b1;
      code_q  <= '0;
    end else begin
      ds_last <= ds_s;
      if (take) code_q <= code;
    end
  end

  a_r4_no_load_deselected: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> $stable(code_q));
  a_r6_loads_bus_value: assert property (@(posedge clk) disable iff (rst)
    !$stable(code_q) |-> code_q == $past(code));
  a_r8_low_level_no_reload: assert property (@(posedge clk) disable iff (rst)
    (!ds_s && !ds_last) |=> $stable(code_q));
endmodule

// File: rtl/pdl_index_gen.sv
module pdl_index_gen #(
  parameter int PTR_W = pdl_pkg::CODE_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PTR_W-1:0] lag,
  output logic [PTR_W-1:0] wr_idx,
  output logic [PTR_W-1:0] rd_idx
);
  always_ff @(posedge clk) begin
    if (rst) wr_idx <= '0;
    else     wr_idx <= wr_idx + 1'b1;
  end

  assign rd_idx = wr_idx - lag;

  a_r1_write_index_steps: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> wr_idx == $past(wr_idx) + 1'b1);
endmodule

// File: rtl/pdl_store.sv
module pdl_store #(
  parameter int DATA_W = pdl_pkg::DATA_W,
  parameter int PTR_W  = pdl_pkg::CODE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [PTR_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    mem[wr_idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[rd_idx];
  end

  a_r3_reset_zero_out: assert property (@(posedge clk)
    rst |=> rdata == '0);
endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line #(
  parameter int DATA_W = pdl_pkg::DATA_W,
  parameter int CODE_W = pdl_pkg::CODE_W,
  parameter int SYNC_N = pdl_pkg::SYNC_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic [CODE_W-1:0] code,
  input  logic              cs_n,
  input  logic              ds_n,
  output logic [DATA_W-1:0] dout
);
  localparam int PTR_W = CODE_W + 1;

  logic [CODE_W-1:0] code_q;
  logic [PTR_W-1:0]  lag;
  logic [PTR_W-1:0]  wr_idx;
  logic [PTR_W-1:0]  rd_idx;

  // lag = 2*code+2, wrapping to 0 for the full-store span
  assign lag = {code_q, 1'b0} + PTR_W'(2);

  pdl_code_latch #(.CODE_W(CODE_W), .SYNC_N(SYNC_N)) u_latch (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ds_n(ds_n),
    .code(code), .code_q(code_q)
  );

  pdl_index_gen #(.PTR_W(PTR_W)) u_idx (
    .clk(clk), .rst(rst), .lag(lag), .wr_idx(wr_idx), .rd_idx(rd_idx)
  );

  pdl_store #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
    .clk(clk), .rst(rst), .wr_idx(wr_idx), .rd_idx(rd_idx),
    .wdata(din), .rdata(dout)
  );

  a_r5_full_span_same_slot: assert property (@(posedge clk) disable iff (rst)
    (code_q == '1) |-> rd_idx == wr_idx);
  a_r9_min_gap_two: assert property (@(posedge clk) disable iff (rst)
    (code_q == '0) |-> PTR_W'(wr_idx - rd_idx) == PTR_W'(2));
endmodule

// File: tb/prog_delay_line_tb.sv
module prog_delay_line_tb;
  localparam int CLK_P = 10;
  localparam int HIST  = 4352;
  localparam int WD    = 100000;
  localparam int NT    = 7;
  localparam logic [10:0] T_CODE [NT] = '{11'd0, 11'd2, 11'd1, 11'd5, 11'd100, 11'd2047, 11'd37};
  localparam int          T_DLY  [NT] = '{2, 6, 4, 12, 202, 4096, 76};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] din = '0;
  logic [10:0] code = '0;
  logic        cs_n = 1'b1;
  logic        ds_n = 1'b1;
  logic [15:0] dout;

  int    checks = 0;
  int    fails  = 0;
  int    ecnt   = 0;
  int    exp_d  = 2;
  int    chk_from = 0;
  bit    chk_en = 1'b0;
  string cur_req = "R1";
  logic [15:0] hist [HIST];

  always #(CLK_P/2) clk = ~clk;

  prog_delay_line u_dut (
    .clk(clk), .rst(rst), .din(din), .code(code),
    .cs_n(cs_n), .ds_n(ds_n), .dout(dout)
  );

  initial begin
    forever begin
      @(posedge clk);
      ecnt++;
      hist[ecnt % HIST] = din;
      @(negedge clk);
      if (chk_en && (ecnt - exp_d > chk_from)) begin
        checks++;
        if (dout !== hist[(ecnt - exp_d) % HIST]) begin
          fails++;
          $display("FAIL %s: edge %0d dout=%h expected %h (delay %0d)",
                   cur_req, ecnt, dout, hist[(ecnt - exp_d) % HIST], exp_d);
        end
      end
      din = 16'(ecnt * 40503 + 7);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic run_check(input int d, input int n, input string tag);
    exp_d = d; cur_req = tag; chk_from = ecnt; chk_en = 1'b1;
    wait_cyc(d + n);
    chk_en = 1'b0;
  endtask

  task automatic load(input logic [10:0] c, input bit sel);
    code = c; cs_n = ~sel; ds_n = 1'b0;
    wait_cyc(3);
    ds_n = 1'b1; cs_n = 1'b1; code = ~c;
    wait_cyc(3);
  endtask

  task automatic check_zero(input string tag);
    @(negedge clk);
    checks++;
    if (dout !== 16'h0000) begin
      fails++;
      $display("FAIL %s: dout=%h expected 0000", tag, dout);
    end
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait_cyc(4);
    check_zero("R3");
    rst = 1'b0;
    #1;
    run_check(2, 40, "R3");

    // table: each load changes the delay in place (R7)
    for (int i = 0; i < NT; i++) begin
      load(T_CODE[i], 1'b1);
      if (T_CODE[i] == 11'd2)         run_check(T_DLY[i], 30, "R2");
      else if (T_CODE[i] == 11'd2047) run_check(T_DLY[i], 30, "R5");
      else if (T_CODE[i] == 11'd0)    run_check(T_DLY[i], 30, "R9");
      else                            run_check(T_DLY[i], 30, "R7");
    end

    // R1 / R6: code changed right after the capture edge
    load(11'd5, 1'b1);
    run_check(12, 30, "R6");
    // R4: strobe with select high must not load 9
    load(11'd9, 1'b0);
    run_check(12, 40, "R4");

    // R8: strobe held low, code changed meanwhile
    code = 11'd3; cs_n = 1'b0; ds_n = 1'b0;
    wait_cyc(3);
    code = 11'd50;
    wait_cyc(10);
    ds_n = 1'b1; cs_n = 1'b1;
    wait_cyc(3);
    run_check(8, 40, "R8");
    run_check(8, 20, "R1");

    // R3: reset again restores code 0 and clears dout
    rst = 1'b1;
    wait_cyc(2);
    check_zero("R3");
    rst = 1'b0;
    #1;
    run_check(2, 30, "R3");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule